// File: doc/BRIEF.md
# Packed SIMD Shift Unit

This unit shifts a 64-bit packed operand by a single 8-bit count, treating the operand as four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane is shifted by the same amount. Three operations are available: logical left, logical right and arithmetic right. Counts beyond the top bit position of a lane clear the lane for the logical operations, and saturate to the top bit position for the arithmetic one, so the lane fills with its sign.

The count can come from three places. In the immediate form, the caller passes a 16-bit instruction word and the unit decodes the operation and the destination index itself. In the register form, the count is the low byte of a 64-bit source value. In the memory form, the count is a byte that the caller has already fetched. The register and immediate forms produce their result one cycle after issue. The memory form produces it two cycles after issue. An illegal immediate encoding raises a one-cycle trap flag instead of a result.

Top module: `simd_shift_unit`

## Requirements
- R1: `lane_sel` 0 selects four 16-bit lanes, 1 selects two 32-bit lanes, and 2 selects one 64-bit lane. Value 3 behaves as the 64-bit lane. Every lane is shifted by the same count.
- R2: For logical left and logical right, a count above the lane width minus one (16 or more, 32 or more, 64 or more) gives an all-zero result.
- R3: For arithmetic right, a count above the lane width minus one is treated as the lane width minus one, so each lane becomes copies of its sign bit.
- R4: The count is an unsigned 8-bit value. Counts from 64 to 255 are over-range for every lane width.
- R5: A count of zero returns the operand unchanged for all three operations.
- R6: Register form (`form` 1, or 3):
  - The count is `count_reg[7:0]`, and the higher bits of `count_reg` have no effect.
  - `op_sel` 0 selects logical left, 1 selects logical right, 2 selects arithmetic right, and 3 selects logical left.
  - `valid` rises one cycle after issue, and `tgt_idx` takes the value of `dst_in`.
- R7: Memory form (`form` 2): the count is `mem_byte`, the operation is given by `op_sel`, and `valid` rises two cycles after issue. The caller leaves `issue` low in the cycle that follows a memory-form issue.
- R8: Immediate form (`form` 0):
  - `instr[5:3]` selects the operation: 2 is logical right, 4 is arithmetic right, and 6 is logical left.
  - `instr[2:0]` is the destination index, returned on `tgt_idx`.
  - `instr[15:8]` is the count.
  - The result is valid one cycle after issue.
- R9: In the immediate form, any other value of `instr[5:3]` pulses `illegal` one cycle after issue. In that case `valid` stays low, and `result` and `tgt_idx` keep their previous values.
- R10: `valid` and `illegal` are never high together, and each operation produces exactly one single-cycle pulse on one of them.
- R11: A synchronous active-high `rst` clears `result`, `tgt_idx`, `valid` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Start one operation this cycle |
| form | input | 2 | Count source: 0 immediate, 1 register, 2 memory, 3 register |
| lane_sel | input | 2 | Lane width select |
| op_sel | input | 2 | Operation for the register and memory forms |
| dst_in | input | 3 | Destination index for the register and memory forms |
| instr | input | 16 | Immediate-form instruction word |
| operand | input | 64 | Packed value to shift |
| count_reg | input | 64 | Register-form count source |
| mem_byte | input | 8 | Memory-form count byte |
| result | output | 64 | Shifted value |
| tgt_idx | output | 3 | Destination index of the result |
| valid | output | 1 | Result strobe, one cycle |
| illegal | output | 1 | Illegal immediate encoding, one cycle |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, a 16-bit base lane and an 8-bit count. With these values all three lane widths are present, and the count range covers zero, each lane's boundary (15/16, 31/32, 63/64) and the far over-range values up to 255. A behavioural model predicts `result`, `tgt_idx`, `valid` and `illegal` for every clock. Directed cases cover each count source, each immediate field value and sign-filled lanes, and a long stretch of random operations mixes all forms back to back.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

   // Operation codes used by the register and memory forms (R6)
   typedef enum logic [1:0] {
      SHOP_LL  = 2'd0,
      SHOP_LR  = 2'd1,
      SHOP_AR  = 2'd2,
      SHOP_LLX = 2'd3
   } shop_e;

   // Count source
   typedef enum logic [1:0] {
      FM_IMM  = 2'd0,
      FM_REG  = 2'd1,
      FM_MEM  = 2'd2,
      FM_REGX = 2'd3
   } form_e;

   // Immediate-form operation field values (instr[5:3]) (R8)
   localparam logic [2:0] IMM_F_LR = 3'd2;
   localparam logic [2:0] IMM_F_AR = 3'd4;
   localparam logic [2:0] IMM_F_LL = 3'd6;

endpackage

// File: rtl/simd_shift_lane.sv
module simd_shift_lane
   import simd_shift_pkg::*;
#(
   parameter int LW    = 16,
   parameter int CNT_W = 8
) (
   input  logic [LW-1:0]    din,
   input  logic [CNT_W-1:0] cnt,
   input  shop_e            op,
   output logic [LW-1:0]    dout
);

   localparam int              SH_W = $clog2(LW);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(LW - 1);

   if (SH_W > CNT_W) begin : g_bad_cnt
      $error("simd_shift_lane: count too narrow for lane width");
   end
   if ((1 << SH_W) != LW) begin : g_bad_lw
      $error("simd_shift_lane: lane width must be a power of two");
   end

   logic            over;
   logic [SH_W-1:0] amt;

   assign over = cnt > TOP;
   assign amt  = over ? SH_W'(LW - 1) : cnt[SH_W-1:0];

   always_comb begin
      case (op)
         SHOP_LR: dout = over ? '0 : (din >> amt);
         SHOP_AR: dout = LW'($signed(din) >>> amt);
         default: dout = over ? '0 : (din << amt);
      endcase
   end

   // Over-range behaviour per operation
   always_comb begin
      if (over && op == SHOP_AR) begin
         assert_sat_fill_R3: assert (dout == {LW{din[LW-1]}});
      end
      if (over && op != SHOP_AR) begin
         assert_over_zero_R2: assert (dout == '0);
      end
   end

endmodule

// File: rtl/simd_shift_bank.sv
module simd_shift_bank
   import simd_shift_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LW     = 16,
   parameter int CNT_W  = 8
) (
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  cnt,
   input  shop_e             op,
   output logic [DATA_W-1:0] dout
);

   localparam int N_LANES = DATA_W / LW;

   if (N_LANES * LW != DATA_W) begin : g_bad_split
      $error("simd_shift_bank: data width not a multiple of lane width");
   end

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      simd_shift_lane #(
         .LW   (LW),
         .CNT_W(CNT_W)
      ) u_lane (
         .din (din[i*LW +: LW]),
         .cnt (cnt),
         .op  (op),
         .dout(dout[i*LW +: LW])
      );
   end

endmodule

// File: rtl/simd_shift_imm_dec.sv
module simd_shift_imm_dec
   import simd_shift_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int CNT_W   = 8,
   parameter int IDX_W   = 3
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               legal,
   output shop_e              op,
   output logic [CNT_W-1:0]   cnt,
   output logic [IDX_W-1:0]   dst
);

   if (INSTR_W < 8 + CNT_W) begin : g_bad_iw
      $error("simd_shift_imm_dec: instruction word too narrow");
   end
   if (IDX_W > 3) begin : g_bad_idx
      $error("simd_shift_imm_dec: index field is at most three bits");
   end

   logic [2:0] fld;

   assign fld = instr[5:3];
   assign cnt = instr[8 +: CNT_W];
   assign dst = instr[IDX_W-1:0];

   always_comb begin
      legal = 1'b1;
      op    = SHOP_LL;
      case (fld)
         IMM_F_LR: op = SHOP_LR;
         IMM_F_AR: op = SHOP_AR;
         IMM_F_LL: op = SHOP_LL;
         default:  legal = 1'b0;
      endcase
   end

   always_comb begin
      if (legal) begin
         assert_legal_field_R8: assert (fld == IMM_F_LR || fld == IMM_F_AR || fld == IMM_F_LL);
      end
   end

endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
   import simd_shift_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int BASE_W  = 16,
   parameter int CNT_W   = 8,
   parameter int IDX_W   = 3,
   parameter int INSTR_W = 16,
   parameter int LSEL_W  = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               issue,
   input  logic [1:0]         form,
   input  logic [LSEL_W-1:0]  lane_sel,
   input  logic [1:0]         op_sel,
   input  logic [IDX_W-1:0]   dst_in,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  operand,
   input  logic [DATA_W-1:0]  count_reg,
   input  logic [CNT_W-1:0]   mem_byte,
   output logic [DATA_W-1:0]  result,
   output logic [IDX_W-1:0]   tgt_idx,
   output logic               valid,
   output logic               illegal
);

   localparam int NUM_WIDTHS = $clog2(DATA_W / BASE_W) + 1;

   if ((BASE_W << (NUM_WIDTHS - 1)) != DATA_W) begin : g_bad_widths
      $error("simd_shift_unit: data width must be base width times a power of two");
   end
   if ((1 << LSEL_W) < NUM_WIDTHS) begin : g_bad_lsel
      $error("simd_shift_unit: lane select too narrow");
   end
   if (DATA_W < CNT_W) begin : g_bad_cnt
      $error("simd_shift_unit: count wider than register source");
   end

   form_e form_e_w;
   assign form_e_w = form_e'(form);

   // Immediate decode
   logic             imm_legal;
   shop_e            imm_op;
   logic [CNT_W-1:0] imm_cnt;
   logic [IDX_W-1:0] imm_dst;

   simd_shift_imm_dec #(
      .INSTR_W(INSTR_W),
      .CNT_W  (CNT_W),
      .IDX_W  (IDX_W)
   ) u_dec (
      .instr(instr),
      .legal(imm_legal),
      .op   (imm_op),
      .cnt  (imm_cnt),
      .dst  (imm_dst)
   );

   // Memory-form hold stage
   logic              pend_q;
   logic [DATA_W-1:0] h_opnd;
   logic [CNT_W-1:0]  h_cnt;
   shop_e             h_op;
   logic [LSEL_W-1:0] h_lsel;
   logic [IDX_W-1:0]  h_dst;

   // Selected operation
   logic [DATA_W-1:0] s_opnd;
   logic [CNT_W-1:0]  s_cnt;
   shop_e             s_op;
   logic [LSEL_W-1:0] s_lsel;
   logic [IDX_W-1:0]  s_dst;

   always_comb begin
      s_opnd = operand;
      s_lsel = lane_sel;
      s_op   = shop_e'(op_sel);
      s_dst  = dst_in;
      s_cnt  = count_reg[CNT_W-1:0];
      if (pend_q) begin
         s_opnd = h_opnd;
         s_lsel = h_lsel;
         s_op   = h_op;
         s_dst  = h_dst;
         s_cnt  = h_cnt;
      end else begin
         case (form_e_w)
            FM_IMM: begin
               s_op  = imm_op;
               s_dst = imm_dst;
               s_cnt = imm_cnt;
            end
            FM_MEM:  s_cnt = mem_byte;
            default: s_cnt = count_reg[CNT_W-1:0];
         endcase
      end
   end

   // One shifter bank per lane width
   logic [DATA_W-1:0] bank_out [NUM_WIDTHS];

   for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
      simd_shift_bank #(
         .DATA_W(DATA_W),
         .LW    (BASE_W << k),
         .CNT_W (CNT_W)
      ) u_bank (
         .din (s_opnd),
         .cnt (s_cnt),
         .op  (s_op),
         .dout(bank_out[k])
      );
   end

   // Lane width select; codes beyond the widest clamp to the widest
   logic [DATA_W-1:0] shifted;
   always_comb begin
      shifted = bank_out[NUM_WIDTHS-1];
      for (int k = 0; k < NUM_WIDTHS; k++) begin
         if (int'(s_lsel) == k) shifted = bank_out[k];
      end
   end

   logic fire, trap, capture;
   assign capture = !pend_q && issue && form_e_w == FM_MEM;
   assign trap    = !pend_q && issue && form_e_w == FM_IMM && !imm_legal;
   assign fire    = pend_q ||
                    (issue && form_e_w != FM_MEM && (form_e_w != FM_IMM || imm_legal));

   always_ff @(posedge clk) begin
      if (rst) begin
         result  <= '0;
         tgt_idx <= '0;
         valid   <= 1'b0;
         illegal <= 1'b0;
         pend_q  <= 1'b0;
         h_opnd  <= '0;
         h_cnt   <= '0;
         h_op    <= SHOP_LL;
         h_lsel  <= '0;
         h_dst   <= '0;
      end else begin
         valid   <= fire;
         illegal <= trap;
         pend_q  <= capture;
         if (fire) begin
            result  <= shifted;
            tgt_idx <= s_dst;
         end
         if (capture) begin
            h_opnd <= operand;
            h_cnt  <= mem_byte;
            h_op   <= shop_e'(op_sel);
            h_lsel <= lane_sel;
            h_dst  <= dst_in;
         end
      end
   end

   logic [DATA_W-CNT_W-1:0] unused_count_hi;
   assign unused_count_hi = count_reg[DATA_W-1:CNT_W];

   assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
      !(valid && illegal));

   assert_mem_latency_R7: assert property (@(posedge clk) disable iff (rst)
      (issue && !pend_q && form_e_w == FM_MEM) |=> (!valid && !illegal) ##1 valid);

   assert_mem_gap_R7: assert property (@(posedge clk) disable iff (rst)
      pend_q |-> !issue);

   assert_reg_latency_R6: assert property (@(posedge clk) disable iff (rst)
      (issue && !pend_q && (form_e_w == FM_REG || form_e_w == FM_REGX)) |=> valid);

   assert_imm_outcome_R8: assert property (@(posedge clk) disable iff (rst)
      (issue && !pend_q && form_e_w == FM_IMM) |=> (valid ^ illegal));

   assert_trap_hold_R9: assert property (@(posedge clk) disable iff (rst)
      illegal |-> ($stable(result) && $stable(tgt_idx)));

endmodule

// File: tb/simd_shift_unit_test.sv
module simd_shift_unit_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        issue = 1'b0;
   logic [1:0]  form = 2'd1;
   logic [1:0]  lane_sel = 2'd0;
   logic [1:0]  op_sel = 2'd0;
   logic [2:0]  dst_in = 3'd0;
   logic [15:0] instr = 16'd0;
   logic [63:0] operand = 64'd0;
   logic [63:0] count_reg = 64'd0;
   logic [7:0]  mem_byte = 8'd0;
   logic [63:0] result;
   logic [2:0]  tgt_idx;
   logic        valid;
   logic        illegal;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_tag = "R11 reset";
   bit    started = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   simd_shift_unit uut (
      .clk(clk), .rst(rst), .issue(issue), .form(form), .lane_sel(lane_sel),
      .op_sel(op_sel), .dst_in(dst_in), .instr(instr), .operand(operand),
      .count_reg(count_reg), .mem_byte(mem_byte), .result(result),
      .tgt_idx(tgt_idx), .valid(valid), .illegal(illegal)
   );

   // Reference shift: op 0/3 logical left, 1 logical right, 2 arithmetic right
   function automatic logic [63:0] ref_shift(logic [63:0] x, int c, int op, int ls);
      int lw, n, cc;
      logic [63:0] mask, v, r, acc;
      lw   = (ls >= 2) ? 64 : (16 << ls);
      mask = (lw == 64) ? {64{1'b1}} : ((64'd1 << lw) - 64'd1);
      n    = 64 / lw;
      acc  = 64'd0;
      for (int i = 0; i < n; i++) begin
         v = (x >> (i * lw)) & mask;
         if (op == 1) begin
            r = (c > lw - 1) ? 64'd0 : (v >> c);
         end else if (op == 2) begin
            cc = (c > lw - 1) ? lw - 1 : c;
            r  = v >> cc;
            if (v[lw-1]) r = r | (mask & ~(mask >> cc));
         end else begin
            r = (c > lw - 1) ? 64'd0 : ((v << c) & mask);
         end
         acc = acc | (r << (i * lw));
      end
      return acc;
   endfunction

   // Cycle model
   logic [63:0] m_res = 64'd0;
   logic [2:0]  m_dst = 3'd0;
   logic        m_vld = 1'b0, m_ill = 1'b0, m_pend = 1'b0;
   string       m_tag = "R11 reset";
   logic [63:0] h_opnd;
   int          h_cnt, h_op, h_ls;
   logic [2:0]  h_dst;
   string       h_tag;

   always @(posedge clk) begin
      if (rst) begin
         m_res <= 64'd0; m_dst <= 3'd0; m_vld <= 1'b0; m_ill <= 1'b0; m_pend <= 1'b0;
         m_tag <= cur_tag;
      end else begin
         m_vld <= 1'b0; m_ill <= 1'b0; m_pend <= 1'b0;
         if (m_pend) begin
            m_res <= ref_shift(h_opnd, h_cnt, h_op, h_ls);
            m_dst <= h_dst; m_vld <= 1'b1; m_tag <= h_tag;
         end else if (issue) begin
            if (form == 2'd0) begin
               int f;
               int o;
               f = int'(instr[5:3]);
               o = (f == 2) ? 1 : (f == 4) ? 2 : 0;
               if (f == 2 || f == 4 || f == 6) begin
                  m_res <= ref_shift(operand, int'(instr[15:8]), o, int'(lane_sel));
                  m_dst <= instr[2:0]; m_vld <= 1'b1;
               end else begin
                  m_ill <= 1'b1;
               end
               m_tag <= cur_tag;
            end else if (form == 2'd2) begin
               h_opnd <= operand; h_cnt <= int'(mem_byte); h_op <= int'(op_sel);
               h_ls <= int'(lane_sel); h_dst <= dst_in; h_tag <= cur_tag;
               m_pend <= 1'b1;
            end else begin
               m_res <= ref_shift(operand, int'(count_reg[7:0]), int'(op_sel), int'(lane_sel));
               m_dst <= dst_in; m_vld <= 1'b1; m_tag <= cur_tag;
            end
         end
      end
   end

   // Compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         n_checks++;
         if (valid !== m_vld || illegal !== m_ill || result !== m_res || tgt_idx !== m_dst) begin
            n_errors++;
            $display("FAIL %s: result=%h idx=%0d valid=%b illegal=%b expected result=%h idx=%0d valid=%b illegal=%b",
                     m_tag, result, tgt_idx, valid, illegal, m_res, m_dst, m_vld, m_ill);
         end
         n_checks++;
         if (valid === 1'b1 && illegal === 1'b1) begin
            n_errors++;
            $display("FAIL R10: valid=%b illegal=%b expected not both high", valid, illegal);
         end
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic op_reg(string tag, int f, int ls, int op, logic [63:0] x,
                         logic [63:0] creg, logic [7:0] mb, logic [2:0] d);
      cur_tag = tag;
      form = 2'(f); lane_sel = 2'(ls); op_sel = 2'(op); operand = x;
      count_reg = creg; mem_byte = mb; dst_in = d; issue = 1'b1;
      step();
      issue = 1'b0;
      if (f == 2) step();
   endtask

   task automatic op_imm(string tag, int ls, logic [2:0] fld, logic [2:0] d,
                         logic [7:0] c, logic [63:0] x);
      cur_tag = tag;
      form = 2'd0; lane_sel = 2'(ls); instr = {c, 2'b00, fld, d}; operand = x; issue = 1'b1;
      step();
      issue = 1'b0;
   endtask

   localparam logic [63:0] PAT = 64'h8123_4567_F9AB_0CDE;

   initial begin
      #(20 * 200000);
      n_errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      step(); step();
      rst = 1'b0;
      started = 1'b1;
      step();
      n_checks++;
      if (result !== 64'd0 || valid !== 1'b0 || illegal !== 1'b0 || tgt_idx !== 3'd0) begin
         n_errors++;
         $display("FAIL R11: result=%h valid=%b illegal=%b idx=%0d expected all zero",
                  result, valid, illegal, tgt_idx);
      end

      // R1: each lane width, all ops, modest count
      for (int ls = 0; ls < 4; ls++)
         for (int op = 0; op < 3; op++)
            op_reg("R1 lane width", 1, ls, op, PAT, 64'd3, 8'd0, 3'(ls));

      // R5: zero count
      for (int ls = 0; ls < 3; ls++)
         for (int op = 0; op < 3; op++)
            op_reg("R5 zero count", 1, ls, op, PAT, 64'd0, 8'd0, 3'd1);

      // R2: logical boundaries
      for (int op = 0; op < 2; op++) begin
         op_reg("R2 lane16 at 15", 1, 0, op, PAT, 64'd15, 8'd0, 3'd2);
         op_reg("R2 lane16 at 16", 1, 0, op, PAT, 64'd16, 8'd0, 3'd2);
         op_reg("R2 lane32 at 31", 1, 1, op, PAT, 64'd31, 8'd0, 3'd2);
         op_reg("R2 lane32 at 32", 1, 1, op, PAT, 64'd32, 8'd0, 3'd2);
         op_reg("R2 lane64 at 63", 1, 2, op, PAT, 64'd63, 8'd0, 3'd2);
         op_reg("R2 lane64 at 64", 1, 2, op, PAT, 64'd64, 8'd0, 3'd2);
      end

      // R3: arithmetic saturation with sign fill
      for (int ls = 0; ls < 3; ls++) begin
         op_reg("R3 sat arith", 1, ls, 2, PAT, 64'd200, 8'd0, 3'd3);
         op_reg("R3 sat arith", 1, ls, 2, ~PAT, 64'd200, 8'd0, 3'd3);
         op_reg("R3 edge arith", 1, ls, 2, PAT, 64'((16 << ls) - 1), 8'd0, 3'd3);
      end

      // R4: large unsigned counts
      op_reg("R4 count 255 left", 1, 2, 0, PAT, 64'd255, 8'd0, 3'd4);
      op_reg("R4 count 128 right", 1, 0, 1, PAT, 64'd128, 8'd0, 3'd4);
      op_reg("R4 count 255 arith", 1, 1, 2, PAT, 64'd255, 8'd0, 3'd4);

      // R6: upper bits of the register source have no effect; op code 3
      op_reg("R6 low byte only", 1, 0, 1, PAT, 64'hFFFF_FFFF_FFFF_FF05, 8'd0, 3'd5);
      op_reg("R6 low byte only", 3, 1, 0, PAT, 64'h0100_0000_0000_0002, 8'd0, 3'd6);
      op_reg("R6 op code three", 1, 0, 3, PAT, 64'd4, 8'd0, 3'd7);

      // R7: memory-sourced count, two-cycle latency
      op_reg("R7 memory count", 2, 0, 2, PAT, 64'd0, 8'd5, 3'd1);
      op_reg("R7 memory count", 2, 1, 1, PAT, 64'hFF, 8'd40, 3'd2);
      op_reg("R7 memory count", 2, 2, 0, PAT, 64'd0, 8'd12, 3'd3);

      // R8: legal immediate encodings
      op_imm("R8 imm right", 0, 3'd2, 3'd5, 8'd4, PAT);
      op_imm("R8 imm arith", 1, 3'd4, 3'd6, 8'd9, PAT);
      op_imm("R8 imm left", 2, 3'd6, 3'd7, 8'd17, PAT);

      // R9: illegal immediate encodings leave result and index alone
      for (int f = 0; f < 8; f++)
         if (f != 2 && f != 4 && f != 6)
            op_imm("R9 illegal field", 0, 3'(f), 3'd1, 8'd3, ~PAT);

      // R11: reset in mid-stream
      cur_tag = "R11 reset mid-run";
      rst = 1'b1; step(); rst = 1'b0; step();

      // R10: random back-to-back mix of all forms
      for (int i = 0; i < 400; i++) begin
         int f;
         f = $urandom_range(0, 3);
         if (f == 0)
            op_imm("R10 random mix", $urandom_range(0, 3), 3'($urandom_range(0, 7)),
                   3'($urandom_range(0, 7)), 8'($urandom), {$urandom, $urandom});
         else
            op_reg("R10 random mix", f, $urandom_range(0, 3), $urandom_range(0, 3),
                   {$urandom, $urandom}, {$urandom, 24'd0, 8'($urandom_range(0, 70))},
                   8'($urandom), 3'($urandom_range(0, 7)));
      end

      step(); step();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule